// File: doc/BRIEF.md
# Configuration Header Register File

This block stores the 256-byte configuration header of one device function and serves configuration accesses to it. A requester presents a byte offset, an access width of one, two or four bytes, and either a read strobe, a write strobe or both. Reads return data one cycle later, packed little-endian. Writes land byte by byte. A protection map selected by the header-type byte decides which bytes are writable. Reserved bits in the upper command byte are cleared on the way in.

Full-word writes to the base-address registers and to the expansion-ROM register take a separate path. The value is aligned to the region size taken from an input, and the region's type bits are merged back in. Implemented bytes of the header are preloaded from parameters at reset. The 16-bit command register is exported, together with a one-cycle strobe that tells the downstream address-window decoder to re-evaluate its windows.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset, bytes 0x00–0x03 hold `ID_WORD`, 0x06–0x07 hold `STATUS_RST`, 0x08–0x0B hold `REV_CLASS`, 0x0E holds `HDR_TYPE`, 0x2C–0x2F hold `SUBSYS_WORD` and 0x3D holds `INT_PIN`, each word little-endian. Every other byte is zero, and `rd_valid` and `remap_o` are low.
- R2: A read strobe makes `rd_valid` high in the next cycle. `rd_data` then carries the addressed bytes with the lowest offset in bits 7:0, and every bit above the effective width is zero.
- R3: `acc_size` encodes 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. A four-byte read at an offset above 0xFC becomes a two-byte read if the offset is at most 0xFE, and a one-byte read otherwise. A two-byte read at 0xFF becomes a one-byte read.
- R4: A write of several bytes stores them from the lowest offset upward. Any byte that would lie beyond offset 0xFF is dropped.
- R5: With header type 0x00 or 0x80, ordinary writes leave bytes 0x00–0x03, 0x06–0x0B, 0x0E, 0x10–0x27, 0x2C–0x2F, 0x30–0x33 and 0x3D unchanged, and store every other byte.
- R6: With header type 0x01 or any other value except 0x00 and 0x80, ordinary writes leave bytes 0x00–0x03, 0x06–0x0B, 0x0E, 0x2C–0x2F, 0x38–0x3B and 0x3D unchanged, and store every other byte.
- R7: Writes to byte 0x05 store only bits 2:0 of the written byte. Bits 7:3 of that byte always read as zero.
- R8: A four-byte write at offsets 0x10–0x27 addresses base region (offset−0x10)/4. If that region's `region_log2` n is non-zero, the write stores (data & ~(2^n−1)) | `region_type`, regardless of header type. One- and two-byte writes there are ordinary writes.
- R9: A four-byte write to a base region whose `region_log2` is zero is an ordinary write.
- R10: A four-byte write at 0x30–0x33 with a non-zero ROM size n (`region_log2` entry 6) stores data & (~(2^n−1) | 1), keeping bit 0 as the enable.
- R11: `remap_o` pulses high for exactly the cycle after a write that overlaps bytes 0x04–0x05 or that takes the R8/R10 path. It stays low otherwise.
- R12: `cmd_o` always equals byte 0x05 concatenated with byte 0x04.
- R13: When a read and a write are presented in the same cycle, the read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 8 | Byte offset of the access |
| acc_size | input | 2 | Access width code (R3) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, lowest offset in bits 7:0 |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| region_log2 | input | 7x5 | Per-region log2 size, entries 0–5 base regions, 6 ROM; 0 = region absent |
| region_type | input | 6x4 | Type bits merged into each base region's low nibble |
| cmd_o | output | 16 | Current command register |
| remap_o | output | 1 | Window re-evaluation strobe |

## Verification
A read and a write can be accepted in the same cycle at the same offset, because the read port samples storage at the very edge the write lands. The bench issues both strobes together on one byte whose value is known. It expects the read to return the pre-write byte, and a later plain read to return the new one. A write overlapping the command word can also coincide with a read of the command bytes, and both `remap_o` and the old read value are judged in the following cycle.

// File: rtl/cfg_hdr_pkg.sv
// Shared layout constants, access-width encoding and byte-level policy
// functions for the configuration header register file.
// Assumes a 256-byte space with six base regions and one ROM region.
package cfg_hdr_pkg;

    localparam int CFG_BYTES  = 256;
    localparam int CFG_AW     = $clog2(CFG_BYTES);
    localparam int BASE_REGS  = 6;
    localparam int REGIONS    = BASE_REGS + 1;
    localparam int LANES      = 4;
    localparam int LOG2_W     = 5;
    localparam int TYPE_W     = 4;

    localparam logic [7:0] OFS_CMD_LO  = 8'h04;
    localparam logic [7:0] OFS_CMD_HI  = 8'h05;
    localparam logic [7:0] OFS_STAT_LO = 8'h06;
    localparam logic [7:0] OFS_STAT_HI = 8'h07;
    localparam logic [7:0] OFS_HDR     = 8'h0E;
    localparam logic [7:0] OFS_BASE0   = 8'h10;
    localparam logic [7:0] OFS_BASE_END = OFS_BASE0 + 8'(4 * BASE_REGS);
    localparam logic [7:0] OFS_ROM     = 8'h30;

    typedef enum logic [1:0] {
        SZ_ONE  = 2'b00,
        SZ_TWO  = 2'b01,
        SZ_FOUR = 2'b10,
        SZ_WIDE = 2'b11
    } acc_sz_e;

    // Number of bytes requested by an access-width code.
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            SZ_ONE:  return 3'd1;
            SZ_TWO:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // True when a byte may not be changed by an ordinary write.
    function automatic logic byte_locked(input logic [7:0] hdr, input logic [7:0] ofs);
        logic std_map;
        logic common;
        std_map = (hdr == 8'h00) || (hdr == 8'h80);
        common  = (ofs <= 8'h03) || (ofs >= 8'h06 && ofs <= 8'h0B) ||
                  (ofs == 8'h0E) || (ofs >= 8'h2C && ofs <= 8'h2F) ||
                  (ofs == 8'h3D);
        if (std_map)
            return common || (ofs >= 8'h10 && ofs <= 8'h27) ||
                   (ofs >= 8'h30 && ofs <= 8'h33);
        return common || (ofs >= 8'h38 && ofs <= 8'h3B);
    endfunction

    // Bits of a byte that an ordinary write is allowed to set.
    function automatic logic [7:0] keep_bits(input logic [7:0] ofs,
                                             input logic [7:0] cmd_hi,
                                             input logic [7:0] st_lo,
                                             input logic [7:0] st_hi);
        case (ofs)
            OFS_CMD_HI:  return cmd_hi;
            OFS_STAT_LO: return st_lo;
            OFS_STAT_HI: return st_hi;
            default:     return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_base_shaper.sv
// Recognises full-word writes to a base-address or ROM register whose
// region is implemented, and forms the value to be stored there.
// Assumes region_log2 = 0 marks an absent region; purely combinational.
module cfg_base_shaper
    import cfg_hdr_pkg::*;
(
    input  logic [7:0]                        acc_addr,
    input  logic [1:0]                        acc_size,
    input  logic [31:0]                       wr_data,
    input  logic [REGIONS-1:0][LOG2_W-1:0]    region_log2,
    input  logic [BASE_REGS-1:0][TYPE_W-1:0]  region_type,
    output logic                              hit,
    output logic [31:0]                       shaped
);

    logic              in_base;
    logic              in_rom;
    logic [2:0]        idx;
    logic [LOG2_W-1:0] lg;
    logic [31:0]       align;
    logic [31:0]       typ;

    // Select the region, derive its alignment mask and build the stored word.
    always_comb begin
        in_base = (acc_addr >= OFS_BASE0) && (acc_addr < OFS_BASE_END);
        in_rom  = (acc_addr >= OFS_ROM) && (acc_addr < OFS_ROM + 8'd4);
        idx     = in_base ? 3'((acc_addr - OFS_BASE0) >> 2) : 3'(BASE_REGS);
        lg      = (in_base || in_rom) ? region_log2[idx] : '0;
        align   = ~((32'd1 << lg) - 32'd1);
        typ     = in_base ? {{(32-TYPE_W){1'b0}}, region_type[idx]} : 32'd0;
        hit     = acc_size[1] && (in_base || in_rom) && (lg != '0);
        shaped  = in_rom ? (wr_data & (align | 32'd1)) : ((wr_data & align) | typ);
    end

endmodule

// File: rtl/cfg_write_lanes.sv
// Splits one write into up to four byte lanes, applying the header-type
// protection map, reserved-bit masks, the end-of-space cut-off and the
// base-register path. Also flags writes that need a window re-evaluation.
module cfg_write_lanes
    import cfg_hdr_pkg::*;
#(
    parameter logic [7:0] CMD_HI_KEEP  = 8'h07,
    parameter logic [7:0] STAT_LO_KEEP = 8'hF8,
    parameter logic [7:0] STAT_HI_KEEP = 8'hF9
)(
    input  logic                    wr_en,
    input  logic [7:0]              acc_addr,
    input  logic [1:0]              acc_size,
    input  logic [31:0]             wr_data,
    input  logic [7:0]              hdr_type,
    input  logic                    base_hit,
    input  logic [31:0]             base_word,
    output logic [LANES-1:0]        lane_we,
    output logic [LANES-1:0][7:0]   lane_ofs,
    output logic [LANES-1:0][7:0]   lane_dat,
    output logic                    remap_req
);

    logic [2:0]               n_bytes;
    logic [LANES-1:0][8:0]    span_ofs;
    logic                     cmd_touch;

    // Per-lane offset, enable and data, plus the command-overlap test.
    always_comb begin
        n_bytes   = size_bytes(acc_size);
        cmd_touch = ({1'b0, acc_addr} <= {1'b0, OFS_CMD_HI}) &&
                    (({1'b0, acc_addr} + {6'd0, n_bytes}) > {1'b0, OFS_CMD_LO});
        remap_req = wr_en && (base_hit || cmd_touch);
        for (int k = 0; k < LANES; k++) begin
            span_ofs[k] = {1'b0, acc_addr} + 9'(k);
            lane_ofs[k] = span_ofs[k][7:0];
            if (base_hit) begin
                lane_we[k]  = wr_en && (3'(k) < n_bytes) && !span_ofs[k][8];
                lane_dat[k] = base_word[8*k +: 8];
            end else begin
                lane_we[k]  = wr_en && (3'(k) < n_bytes) && !span_ofs[k][8] &&
                              !byte_locked(hdr_type, span_ofs[k][7:0]);
                lane_dat[k] = wr_data[8*k +: 8] &
                              keep_bits(span_ofs[k][7:0], CMD_HI_KEEP,
                                        STAT_LO_KEEP, STAT_HI_KEEP);
            end
        end
    end

endmodule

// File: rtl/cfg_read_port.sv
// Registered read port: narrows the access width near the top of the
// space and packs the bytes little-endian, one cycle after the strobe.
// Samples storage before any write landing on the same edge.
module cfg_read_port
    import cfg_hdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic [7:0]  acc_addr,
    input  logic [1:0]  acc_size,
    input  logic [7:0]  cfg_bytes [CFG_BYTES],
    output logic [31:0] rd_data,
    output logic        rd_valid
);

    logic [2:0]  eff_n;
    logic [2:0]  eff_q;
    logic [31:0] packed_w;

    // Effective width after end-of-space fall-back, and the packed word.
    always_comb begin
        if (acc_size[1] && acc_addr <= 8'hFC)
            eff_n = 3'd4;
        else if (acc_size != SZ_ONE && acc_addr <= 8'hFE)
            eff_n = 3'd2;
        else
            eff_n = 3'd1;
        packed_w = {24'd0, cfg_bytes[acc_addr]};
        if (eff_n >= 3'd2)
            packed_w[15:8] = cfg_bytes[acc_addr + 8'd1];
        if (eff_n == 3'd4) begin
            packed_w[23:16] = cfg_bytes[acc_addr + 8'd2];
            packed_w[31:24] = cfg_bytes[acc_addr + 8'd3];
        end
    end

    // Capture read result and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            eff_q    <= 3'd1;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= packed_w;
                eff_q   <= eff_n;
            end
        end
    end

    p_rd_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && eff_q == 3'd1) |-> (rd_data[31:8] == 24'd0));

endmodule

// File: rtl/cfg_header_regs.sv
// Configuration header register file: 256 bytes of storage with reset
// preload, byte-lane writes through the protection/shaping logic, a
// registered read port, the exported command word and a remap strobe.
// Assumes one access per cycle; read and write may share a cycle.
module cfg_header_regs
    import cfg_hdr_pkg::*;
#(
    parameter logic [31:0] ID_WORD      = 32'h0000_0000,
    parameter logic [15:0] STATUS_RST   = 16'h0000,
    parameter logic [31:0] REV_CLASS    = 32'h0000_0000,
    parameter logic [7:0]  HDR_TYPE     = 8'h00,
    parameter logic [31:0] SUBSYS_WORD  = 32'h0000_0000,
    parameter logic [7:0]  INT_PIN      = 8'h00,
    parameter logic [7:0]  CMD_HI_KEEP  = 8'h07,
    parameter logic [7:0]  STAT_LO_KEEP = 8'hF8,
    parameter logic [7:0]  STAT_HI_KEEP = 8'hF9
)(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [7:0]                        acc_addr,
    input  logic [1:0]                        acc_size,
    input  logic                              wr_en,
    input  logic [31:0]                       wr_data,
    input  logic                              rd_en,
    output logic [31:0]                       rd_data,
    output logic                              rd_valid,
    input  logic [REGIONS-1:0][LOG2_W-1:0]    region_log2,
    input  logic [BASE_REGS-1:0][TYPE_W-1:0]  region_type,
    output logic [15:0]                       cmd_o,
    output logic                              remap_o
);

    logic [7:0]               cfg_mem [CFG_BYTES];
    logic                     base_hit;
    logic [31:0]              base_word;
    logic [LANES-1:0]         lane_we;
    logic [LANES-1:0][7:0]    lane_ofs;
    logic [LANES-1:0][7:0]    lane_dat;
    logic                     remap_req;
    logic                     remap_q;

    // Reset contents of one header byte, taken from the parameters.
    function automatic logic [7:0] preload(input logic [7:0] ofs);
        case (ofs)
            8'h00, 8'h01, 8'h02, 8'h03: return ID_WORD[8*ofs[1:0] +: 8];
            8'h06, 8'h07:               return STATUS_RST[8*ofs[0] +: 8];
            8'h08, 8'h09, 8'h0A, 8'h0B: return REV_CLASS[8*ofs[1:0] +: 8];
            OFS_HDR:                    return HDR_TYPE;
            8'h2C, 8'h2D, 8'h2E, 8'h2F: return SUBSYS_WORD[8*ofs[1:0] +: 8];
            8'h3D:                      return INT_PIN;
            default:                    return 8'h00;
        endcase
    endfunction

    cfg_base_shaper u_shaper (
        .acc_addr    (acc_addr),
        .acc_size    (acc_size),
        .wr_data     (wr_data),
        .region_log2 (region_log2),
        .region_type (region_type),
        .hit         (base_hit),
        .shaped      (base_word)
    );

    cfg_write_lanes #(
        .CMD_HI_KEEP  (CMD_HI_KEEP),
        .STAT_LO_KEEP (STAT_LO_KEEP),
        .STAT_HI_KEEP (STAT_HI_KEEP)
    ) u_lanes (
        .wr_en     (wr_en),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .wr_data   (wr_data),
        .hdr_type  (cfg_mem[OFS_HDR]),
        .base_hit  (base_hit),
        .base_word (base_word),
        .lane_we   (lane_we),
        .lane_ofs  (lane_ofs),
        .lane_dat  (lane_dat),
        .remap_req (remap_req)
    );

    cfg_read_port u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .cfg_bytes (cfg_mem),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // Header storage: preload on reset, then per-lane byte updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CFG_BYTES; i++)
                cfg_mem[i] <= preload(8'(i));
        end else begin
            for (int k = 0; k < LANES; k++)
                if (lane_we[k])
                    cfg_mem[lane_ofs[k]] <= lane_dat[k];
        end
    end

    // Window re-evaluation strobe, one cycle after the triggering write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remap_q <= 1'b0;
        else
            remap_q <= remap_req;
    end

    assign remap_o = remap_q;
    assign cmd_o   = {cfg_mem[OFS_CMD_HI], cfg_mem[OFS_CMD_LO]};

    p_remap_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        remap_o |-> $past(wr_en));

    p_remap_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_addr == OFS_CMD_LO) |=> remap_o);

    p_id_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable({cfg_mem[0], cfg_mem[1], cfg_mem[2], cfg_mem[3]}));

    p_hdr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(cfg_mem[OFS_HDR]));

    p_cmd_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o[15:8] & ~CMD_HI_KEEP) == 8'h00);

endmodule

// File: tb/sim_cfg_header_regs.sv
module sim_cfg_header_regs;

    localparam int NI = 4;
    localparam logic [7:0]  HDRS [NI] = '{8'h00, 8'h01, 8'h80, 8'h05};
    localparam logic [31:0] P_ID   = 32'h7A31_C0DE;
    localparam logic [15:0] P_ST   = 16'h0210;
    localparam logic [31:0] P_RC   = 32'h0C03_2001;
    localparam logic [31:0] P_SUB  = 32'h4E21_9B07;
    localparam logic [7:0]  P_PIN  = 8'h02;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        acc_addr = '0;
    logic [1:0]        acc_size = '0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [6:0][4:0]   rlog = {5'd11, 5'd2, 5'd0, 5'd12, 5'd0, 5'd8, 5'd4};
    logic [5:0][3:0]   rtyp = {4'h0, 4'h0, 4'h0, 4'h8, 4'h0, 4'h1};
    logic [31:0]       rdat [NI];
    logic              rval [NI];
    logic [15:0]       cmdv [NI];
    logic              rmp  [NI];
    logic [7:0]        model [NI][256];
    int                n_chk = 0;
    int                n_fail = 0;
    bit                done = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar gi = 0; gi < NI; gi++) begin : g_dut
        cfg_header_regs #(
            .ID_WORD(P_ID), .STATUS_RST(P_ST), .REV_CLASS(P_RC),
            .HDR_TYPE(HDRS[gi]), .SUBSYS_WORD(P_SUB), .INT_PIN(P_PIN)
        ) u0 (
            .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_size(acc_size),
            .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
            .rd_data(rdat[gi]), .rd_valid(rval[gi]),
            .region_log2(rlog), .region_type(rtyp),
            .cmd_o(cmdv[gi]), .remap_o(rmp[gi])
        );
    end

    function automatic bit ro_ref(input logic [7:0] h, input logic [7:0] a);
        bit c = (a <= 8'h03) || (a >= 8'h06 && a <= 8'h0B) || a == 8'h0E ||
                (a >= 8'h2C && a <= 8'h2F) || a == 8'h3D;
        if (h == 8'h00 || h == 8'h80)
            return c || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
        return c || (a >= 8'h38 && a <= 8'h3B);
    endfunction

    function automatic logic [7:0] rst_ref(input int i, input logic [7:0] h);
        if (i <= 3) return P_ID[8*i +: 8];
        if (i == 6 || i == 7) return P_ST[8*(i-6) +: 8];
        if (i >= 8 && i <= 11) return P_RC[8*(i-8) +: 8];
        if (i == 14) return h;
        if (i >= 44 && i <= 47) return P_SUB[8*(i-44) +: 8];
        if (i == 61) return P_PIN;
        return 8'h00;
    endfunction

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    // Applies one write to the reference model; returns the expected strobe.
    function automatic bit apply_write(input logic [7:0] a, input logic [1:0] s,
                                       input logic [31:0] d);
        int n = nbytes(s);
        bit inb = (a >= 8'h10 && a < 8'h28);
        bit inr = (a >= 8'h30 && a < 8'h34);
        int lg = inb ? int'(rlog[(a - 8'h10) / 4]) : inr ? int'(rlog[6]) : 0;
        logic [31:0] al = ~((32'd1 << lg) - 1);
        bit hit = (n == 4) && lg != 0;
        logic [31:0] sh = inr ? (d & (al | 32'd1))
                              : ((d & al) | (inb ? {28'd0, rtyp[(a - 8'h10) / 4]} : 32'd0));
        for (int i = 0; i < NI; i++)
            for (int k = 0; k < n; k++) begin
                int o = int'(a) + k;
                if (o > 255) continue;
                if (hit) model[i][o] = sh[8*k +: 8];
                else if (!ro_ref(HDRS[i], 8'(o)))
                    model[i][o] = d[8*k +: 8] & ((o == 5) ? 8'h07 : 8'hFF);
            end
        return hit || (int'(a) <= 5 && int'(a) + n > 4);
    endfunction

    function automatic logic [31:0] exp_read(input int i, input logic [7:0] a,
                                             input logic [1:0] s);
        int n = (s[1] && a <= 8'hFC) ? 4 : (s != 2'd0 && a <= 8'hFE) ? 2 : 1;
        logic [31:0] e = {24'd0, model[i][a]};
        if (n >= 2) e[15:8] = model[i][int'(a) + 1];
        if (n == 4) begin
            e[23:16] = model[i][int'(a) + 2];
            e[31:24] = model[i][int'(a) + 3];
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NI; i++)
            for (int b = 0; b < 256; b++) model[i][b] = rst_ref(b, HDRS[i]);
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        bit er;
        @(negedge clk);
        acc_addr = a; acc_size = s; wr_data = d; wr_en = 1'b1;
        er = apply_write(a, s, d);
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < NI; i++) begin
            chk(rmp[i] == er, "R11 remap", 32'(rmp[i]), 32'(er));
            chk(cmdv[i] == {model[i][5], model[i][4]}, "R12 cmd",
                32'(cmdv[i]), {16'd0, model[i][5], model[i][4]});
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] s,
                      input string tstd, input string tbrg);
        logic [31:0] e;
        @(negedge clk);
        acc_addr = a; acc_size = s; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        for (int i = 0; i < NI; i++) begin
            e = exp_read(i, a, s);
            chk(rval[i], "R2 valid", 32'(rval[i]), 32'd1);
            chk(rdat[i] == e, (HDRS[i] == 8'h00 || HDRS[i] == 8'h80) ? tstd : tbrg,
                rdat[i], e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state of every byte and of the strobes
        for (int i = 0; i < NI; i++) begin
            chk(!rval[i], "R1 rd_valid", 32'(rval[i]), 0);
            chk(!rmp[i], "R1 remap", 32'(rmp[i]), 0);
        end
        for (int a = 0; a < 256; a++) rd(8'(a), 2'd0, "R1", "R1");

        // R5 R6 R7: single-byte write sweep, then readback of every byte
        for (int a = 0; a < 256; a++) wr(8'(a), 2'd0, {24'd0, 8'(a) ^ 8'hA5});
        for (int a = 0; a < 256; a++)
            rd(8'(a), 2'd0, (a == 5) ? "R7" : "R5", (a == 5) ? "R7" : "R6");

        // R2 R3: every offset at two and four bytes, including fall-back
        for (int a = 0; a < 256; a++)
            rd(8'(a), 2'd2, (a > 252) ? "R3" : "R2", (a > 252) ? "R3" : "R2");
        for (int a = 250; a < 256; a++) rd(8'(a), 2'd3, "R3", "R3");
        for (int a = 0; a < 256; a++)
            rd(8'(a), 2'd1, (a == 255) ? "R3" : "R2", (a == 255) ? "R3" : "R2");

        // R8 R9 R10: base and ROM register paths
        do_reset();
        wr(8'h10, 2'd2, 32'hFFFF_FFFF);
        wr(8'h14, 2'd2, 32'h1234_5678);
        wr(8'h18, 2'd2, 32'hCAFE_F00D);
        wr(8'h1C, 2'd2, 32'hDEAD_BEEF);
        wr(8'h20, 2'd3, 32'h0BAD_0BAD);
        wr(8'h24, 2'd2, 32'hFFFF_FFFF);
        wr(8'h14, 2'd1, 32'h0000_AAAA);
        wr(8'h30, 2'd2, 32'hFFFF_F7FF);
        wr(8'h38, 2'd2, 32'h5566_7788);
        for (int a = 8'h10; a < 8'h3C; a += 4)
            rd(8'(a), 2'd2, (a == 8'h18 || a == 8'h20) ? "R9" : (a >= 8'h30) ? "R10" : "R8",
                            (a == 8'h18 || a == 8'h20) ? "R9" : (a >= 8'h30) ? "R10" : "R8");
        wr(8'h30, 2'd2, 32'h0001_0000);
        rd(8'h30, 2'd2, "R10", "R10");

        // R4: writes running past the end of the space
        wr(8'hFD, 2'd2, 32'h1122_3344);
        rd(8'hFC, 2'd2, "R4", "R4");
        rd(8'h00, 2'd2, "R4", "R4");
        wr(8'hFF, 2'd1, 32'h0000_9966);
        rd(8'hFE, 2'd1, "R4", "R4");
        rd(8'h00, 2'd1, "R4", "R4");

        // R11 R12: command overlap and non-overlap writes
        wr(8'h03, 2'd1, 32'h0000_FFFF);
        wr(8'h02, 2'd2, 32'h0000_0000);
        wr(8'h05, 2'd0, 32'h0000_00FF);
        wr(8'h06, 2'd1, 32'h0000_FFFF);
        wr(8'h40, 2'd2, 32'h0102_0304);
        rd(8'h04, 2'd1, "R12", "R12");

        // R13: read and write in the same cycle
        for (int r = 0; r < 3; r++) begin
            logic [31:0] e0;
            @(negedge clk);
            acc_addr = 8'h41; acc_size = 2'd0; wr_data = 32'(8'h70 + r);
            wr_en = 1'b1; rd_en = 1'b1;
            e0 = exp_read(0, 8'h41, 2'd0);
            void'(apply_write(8'h41, 2'd0, 32'(8'h70 + r)));
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
            chk(rdat[0] == e0, "R13 old data", rdat[0], e0);
            rd(8'h41, 2'd0, "R13", "R13");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule